// File: doc/BRIEF.md
# Loop-closing branch controller

This block resolves the branch at the bottom of a loop body for two kinds of loop. A plain counted loop keeps its trip count in a dedicated loop counter, so no general register is needed. The branch goes back while that counter is nonzero and decrements it on each pass. Loading the counter with N gives N+1 executions of the body.

A software-pipelined counted loop also uses a drain counter. The loop counter is used up first. After that the drain counter is decremented, so that the later pipeline stages can finish the iterations already in flight. On every back-edge of a pipelined loop the block requests one register rotation. It also supplies the predicate value that enables the first pipeline stage: 1 while the loop counter is still nonzero, and 0 during the drain phase. Stage k of the loop is gated by the predicate that was injected k-1 rotations earlier.

Software loads either counter through a write port. The decision for a branch presented in one cycle appears on the registered result outputs in the next cycle, together with the updated counters.

Top module: `loopbr_ctrl`

## Requirements
- R1: After synchronous reset both counters read 0 and res_valid, res_taken, res_rotate and res_stage_pred are 0.
- R2: A counted branch (br_kind = 0) with loop counter L > 0 is taken and leaves the loop counter at L-1. Loading 5 yields 5 taken branches, which is 6 body executions.
- R3: A counted branch with loop counter 0 is not taken and leaves the loop counter at 0.
- R4: A counted branch never asserts res_rotate or res_stage_pred and leaves the drain counter unchanged.
- R5: A pipelined branch (br_kind = 1) with loop counter L > 0 is taken, asserts res_rotate and res_stage_pred = 1, sets the loop counter to L-1 and leaves the drain counter unchanged.
- R6: A pipelined branch with loop counter 0 and drain counter E > 1 is taken, asserts res_rotate with res_stage_pred = 0, and sets the drain counter to E-1.
- R7: A pipelined branch with loop counter 0 and drain counter E <= 1 falls through with neither rotation nor stage predicate, and leaves the drain counter at 0. From loads L and E, the pipelined loop is therefore taken L + max(E-1, 0) times.
- R8: A software write to a counter in the same cycle as a branch sets that counter to the written value and overrides the branch update. The other counter still follows the branch.
- R9: The result of a branch presented in cycle t is on res_* in cycle t+1, with res_valid = 1. In cycles with res_valid = 0, res_taken, res_rotate and res_stage_pred are 0.
- R10: In a cycle with no branch and no write, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A loop branch is evaluated this cycle |
| br_kind | input | 1 | 0 = counted loop, 1 = pipelined loop |
| lc_wr_en | input | 1 | Load the loop counter |
| lc_wr_data | input | CNT_W | Loop counter load value |
| ec_wr_en | input | 1 | Load the drain counter |
| ec_wr_data | input | CNT_W | Drain counter load value |
| lc_q | output | CNT_W | Current loop counter |
| ec_q | output | CNT_W | Current drain counter |
| res_valid | output | 1 | Registered result is valid |
| res_taken | output | 1 | Branch taken |
| res_rotate | output | 1 | Register rotation request |
| res_stage_pred | output | 1 | First-stage predicate value to inject |

## Verification
The assertions check the per-cycle rules on every cycle:
- the decrement and hold behaviour of each counter under both branch kinds;
- write priority;
- a silent result output when no branch was issued.

Properties that cover a whole loop need the bench's sweeps, which load every combination of loop count and drain count over a small range and run each loop until it falls through. These include the total taken count for each loop kind, the point at which the stage predicate switches from 1 to 0, and the fact that a loop which has fallen through stays closed.

// File: rtl/loopbr_pkg.sv
package loopbr_pkg;

    typedef enum logic {
        BR_COUNTED   = 1'b0,
        BR_PIPELINED = 1'b1
    } br_kind_e;

    // One resolved loop step: branch outcome plus counter update requests.
    typedef struct packed {
        logic taken;
        logic rotate;
        logic stage_pred;
        logic lc_dec;
        logic ec_dec;
    } loop_step_t;

    localparam loop_step_t STEP_IDLE = '{default: 1'b0};

    // Decision rule in terms of counter-zero flags only.
    function automatic loop_step_t decide_step(
        input br_kind_e kind,
        input logic     lc_nz,
        input logic     ec_gt1,
        input logic     ec_nz
    );
        loop_step_t s;
        s = STEP_IDLE;
        if (kind == BR_COUNTED) begin
            s.taken  = lc_nz;
            s.lc_dec = lc_nz;
        end else if (lc_nz) begin
            s.taken      = 1'b1;
            s.rotate     = 1'b1;
            s.stage_pred = 1'b1;
            s.lc_dec     = 1'b1;
        end else if (ec_gt1) begin
            s.taken  = 1'b1;
            s.rotate = 1'b1;
            s.ec_dec = 1'b1;
        end else begin
            // Fall-through: drain counter settles at zero, no rotation.
            s.ec_dec = ec_nz;
        end
        return s;
    endfunction

endpackage

// File: rtl/loopbr_eval.sv
module loopbr_eval
    import loopbr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  br_kind_e            kind,
    input  logic [CNT_W-1:0]    lc,
    input  logic [CNT_W-1:0]    ec,
    output loop_step_t          step
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic lc_nz, ec_nz, ec_gt1;

    always_comb begin
        lc_nz  = |lc;
        ec_nz  = |ec;
        ec_gt1 = ec > ONE;
        step   = decide_step(kind, lc_nz, ec_gt1, ec_nz);
    end
endmodule

// File: rtl/loopbr_counter.sv
module loopbr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             dec,
    output logic [CNT_W-1:0] q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wr_data;
        else if (dec && q != '0)
            q <= q - ONE;
    end

    // R8: a load always wins over a decrement.
    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> q == $past(wr_data));

    // R10: with no load and no decrement the value holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !dec) |=> $stable(q));
endmodule

// File: rtl/loopbr_ctrl.sv
module loopbr_ctrl
    import loopbr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_valid,
    input  logic             br_kind,
    input  logic             lc_wr_en,
    input  logic [CNT_W-1:0] lc_wr_data,
    input  logic             ec_wr_en,
    input  logic [CNT_W-1:0] ec_wr_data,
    output logic [CNT_W-1:0] lc_q,
    output logic [CNT_W-1:0] ec_q,
    output logic             res_valid,
    output logic             res_taken,
    output logic             res_rotate,
    output logic             res_stage_pred
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    br_kind_e   kind;
    loop_step_t step;
    logic       lc_dec, ec_dec;

    assign kind = br_kind_e'(br_kind);

    loopbr_eval #(.CNT_W(CNT_W)) u_eval (
        .kind (kind),
        .lc   (lc_q),
        .ec   (ec_q),
        .step (step)
    );

    assign lc_dec = br_valid && step.lc_dec;
    assign ec_dec = br_valid && step.ec_dec;

    loopbr_counter #(.CNT_W(CNT_W)) u_lc (
        .clk (clk), .rst (rst),
        .wr_en (lc_wr_en), .wr_data (lc_wr_data),
        .dec (lc_dec), .q (lc_q)
    );

    loopbr_counter #(.CNT_W(CNT_W)) u_ec (
        .clk (clk), .rst (rst),
        .wr_en (ec_wr_en), .wr_data (ec_wr_data),
        .dec (ec_dec), .q (ec_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid      <= 1'b0;
            res_taken      <= 1'b0;
            res_rotate     <= 1'b0;
            res_stage_pred <= 1'b0;
        end else begin
            res_valid      <= br_valid;
            res_taken      <= br_valid && step.taken;
            res_rotate     <= br_valid && step.rotate;
            res_stage_pred <= br_valid && step.stage_pred;
        end
    end

    // R2: counted back-edge from a nonzero counter.
    a_r2_counted_taken: assert property (@(posedge clk) disable iff (rst)
        (br_valid && kind == BR_COUNTED && lc_q != '0 && !lc_wr_en)
        |=> res_taken && lc_q == $past(lc_q) - ONE);

    // R3: counted exit at zero.
    a_r3_counted_exit: assert property (@(posedge clk) disable iff (rst)
        (br_valid && kind == BR_COUNTED && lc_q == '0 && !lc_wr_en)
        |=> !res_taken && lc_q == '0);

    // R4: counted branch leaves rotation, predicate and drain counter alone.
    a_r4_counted_quiet: assert property (@(posedge clk) disable iff (rst)
        (br_valid && kind == BR_COUNTED && !ec_wr_en)
        |=> !res_rotate && !res_stage_pred && $stable(ec_q));

    // R5: pipelined kernel iteration.
    a_r5_kernel: assert property (@(posedge clk) disable iff (rst)
        (br_valid && kind == BR_PIPELINED && lc_q != '0 && !lc_wr_en && !ec_wr_en)
        |=> res_taken && res_rotate && res_stage_pred
            && lc_q == $past(lc_q) - ONE && $stable(ec_q));

    // R6: pipelined drain iteration.
    a_r6_drain: assert property (@(posedge clk) disable iff (rst)
        (br_valid && kind == BR_PIPELINED && lc_q == '0 && ec_q > ONE && !ec_wr_en)
        |=> res_taken && res_rotate && !res_stage_pred
            && ec_q == $past(ec_q) - ONE);

    // R7: pipelined fall-through.
    a_r7_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (br_valid && kind == BR_PIPELINED && lc_q == '0 && ec_q <= ONE && !ec_wr_en)
        |=> !res_taken && !res_rotate && !res_stage_pred && ec_q == '0);

    // R9: results are silent without a branch.
    a_r9_silent: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_taken && !res_rotate && !res_stage_pred);
endmodule

// File: tb/loopbr_ctrl_bench.sv
`timescale 1ns/1ps
module loopbr_ctrl_bench;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst;
    logic br_valid, br_kind, lc_wr_en, ec_wr_en;
    logic [CNT_W-1:0] lc_wr_data, ec_wr_data, lc_q, ec_q;
    logic res_valid, res_taken, res_rotate, res_stage_pred;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    loopbr_ctrl #(.CNT_W(CNT_W)) u_loopbr_ctrl (
        .clk (clk), .rst (rst),
        .br_valid (br_valid), .br_kind (br_kind),
        .lc_wr_en (lc_wr_en), .lc_wr_data (lc_wr_data),
        .ec_wr_en (ec_wr_en), .ec_wr_data (ec_wr_data),
        .lc_q (lc_q), .ec_q (ec_q),
        .res_valid (res_valid), .res_taken (res_taken),
        .res_rotate (res_rotate), .res_stage_pred (res_stage_pred)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        br_valid = 0; br_kind = 0; lc_wr_en = 0; ec_wr_en = 0;
        lc_wr_data = '0; ec_wr_data = '0;
    endtask

    task automatic load(input int l, input int e);
        @(negedge clk);
        lc_wr_en = 1; lc_wr_data = CNT_W'(l);
        ec_wr_en = 1; ec_wr_data = CNT_W'(e);
        @(negedge clk);
        idle_inputs();
        check("R8 load lc", int'(lc_q), l);
        check("R8 load ec", int'(ec_q), e);
    endtask

    // One branch, checked against an arithmetic model; returns taken.
    task automatic branch(input bit kind, inout int ml, inout int me, output bit tk);
        bit et, er, ep;
        et = 0; er = 0; ep = 0;
        if (!kind) begin
            et = (ml > 0);
            if (ml > 0) ml--;
        end else if (ml > 0) begin
            et = 1; er = 1; ep = 1; ml--;
        end else if (me > 1) begin
            et = 1; er = 1; me--;
        end else begin
            me = 0;
        end
        @(negedge clk);
        br_valid = 1; br_kind = kind;
        @(negedge clk);
        idle_inputs();
        if (!kind) begin
            check(et ? "R2 taken" : "R3 taken", int'(res_taken), int'(et));
            check("R4 rotate", int'(res_rotate), 0);
            check("R4 pred", int'(res_stage_pred), 0);
        end else begin
            check(ep ? "R5 taken" : (et ? "R6 taken" : "R7 taken"), int'(res_taken), int'(et));
            check(ep ? "R5 rotate" : (et ? "R6 rotate" : "R7 rotate"), int'(res_rotate), int'(er));
            check(ep ? "R5 pred" : "R6 pred", int'(res_stage_pred), int'(ep));
        end
        check("R9 valid", int'(res_valid), 1);
        check("R2 lc", int'(lc_q), ml);
        check("R6 ec", int'(ec_q), me);
        tk = et;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int ml, me, taken_n;
        bit tk;
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 lc", int'(lc_q), 0);
        check("R1 ec", int'(ec_q), 0);
        check("R1 valid", int'(res_valid), 0);
        check("R1 taken", int'(res_taken), 0);
        check("R1 rotate", int'(res_rotate), 0);
        check("R1 pred", int'(res_stage_pred), 0);

        // R2: load 5 -> 5 taken, 6 body executions
        load(5, 3);
        ml = 5; me = 3; taken_n = 0;
        do begin branch(0, ml, me, tk); taken_n += tk; end while (tk);
        check("R2 bodies for 5", taken_n + 1, 6);
        check("R4 ec untouched", int'(ec_q), 3);
        branch(0, ml, me, tk);  // R3 again at zero
        check("R3 stays closed", int'(tk), 0);

        // Sweep both kinds over loop and drain counts (R2..R7)
        for (int k = 0; k < 2; k++) begin
            for (int l = 0; l < 10; l++) begin
                for (int e = 0; e < 5; e++) begin
                    load(l, e);
                    ml = l; me = e; taken_n = 0;
                    do begin branch(k[0], ml, me, tk); taken_n += tk; end while (tk && taken_n < 64);
                    if (k == 0)
                        check("R2 total taken", taken_n, l);
                    else
                        check("R7 total taken", taken_n, l + ((e > 1) ? e - 1 : 0));
                    branch(k[0], ml, me, tk);
                    check("R7 closed after exit", int'(tk), 0);
                end
            end
        end

        // R10: idle cycles hold counters and keep results silent (R9)
        load(7, 4);
        repeat (3) @(negedge clk);
        check("R10 lc hold", int'(lc_q), 7);
        check("R10 ec hold", int'(ec_q), 4);
        check("R9 silent taken", int'(res_taken), 0);
        check("R9 silent rotate", int'(res_rotate), 0);

        // R8: lc write beats a kernel branch; ec follows nothing (lc nonzero)
        @(negedge clk);
        br_valid = 1; br_kind = 1; lc_wr_en = 1; lc_wr_data = 8'd20;
        @(negedge clk);
        idle_inputs();
        check("R8 lc wins", int'(lc_q), 20);
        check("R8 ec", int'(ec_q), 4);
        check("R5 taken with write", int'(res_taken), 1);

        // R8: ec write beats a drain branch; lc still follows branch rules
        load(0, 6);
        @(negedge clk);
        br_valid = 1; br_kind = 1; ec_wr_en = 1; ec_wr_data = 8'd9;
        @(negedge clk);
        idle_inputs();
        check("R8 ec wins", int'(ec_q), 9);
        check("R8 lc", int'(lc_q), 0);
        check("R6 taken with write", int'(res_taken), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule